// File: doc/BRIEF.md
# TDM Time-Slot Assigner Engine

This block divides a serial time-division-multiplexed frame into slots and hands each slot to one of several internal channel ports. It walks a small routing table, one entry per slot. Each entry gives a channel selector, a length and a flag that marks the final slot of the frame. The receive walker raises a per-channel strobe for every bit that belongs to that channel and presents the line bit alongside it. The transmit walker raises a per-channel request strobe and drives the serial output from the selected channel's bit. The two walkers have their own table halves and can share one frame sync or run from separate syncs.

Each walker is a three-state machine. OFF is held while the engine is disabled. WAIT idles until a frame sync. RUN steps through entries. The transitions are: OFF to WAIT when enabled with no sync, and any state to RUN when enabled with a sync sampled. Inside RUN, the walker moves to the next entry when a slot's last unit ends. RUN goes to WAIT when the slot that ends is the flagged last entry or the final table row. Any state goes to OFF when the enable drops. In double-speed mode each data bit spans two clock cycles, and the strobe appears in the second of them.

Software loads the table only while the engine is disabled. Then it sets the enable and supplies frame syncs.

Top module: `tsa_engine`

## Requirements
- R1: A slot lasts count+1 units. The unit is one bit when the unit flag is 0 and eight bits when it is 1. For example, count 0 in bytes is 8 bits and count 1 in bits is 2 bits.
- R2: A selector of 0, or a selector above the number of channels, serves no channel. Its bits raise no strobe.
- R3: A selector value k from 1 to NCH owns strobe bit k-1 for every bit of its slot. At most one strobe bit per direction is high at a time. rx_data equals rx_line while a receive strobe is high and is 0 otherwise.
- R4: After the slot of an entry with the last flag ends, no strobe is raised until the next sync. The walk also ends after table row NE-1 when no row carries the flag.
- R5: A sync that is high at a rising clock edge while the engine is enabled starts the walk at entry 0 with the next cycle. This holds even in the middle of a frame, and it aborts the current slot.
- R6: The entry word is 9 bits: selector in [8:5], count in [4:2], unit flag in [1] (1 = bytes), last flag in [0]. Addresses 0..NE-1 hold the transmit table and NE..2NE-1 hold the receive table.
- R7: A table write made while en is 1 is ignored. A write made while en is 0 takes effect.
- R8: With shared_sync at 1, rx_sync starts both walkers. With shared_sync at 0, tx_sync alone starts the transmit walker.
- R9: With dbl_speed at 1, each bit occupies two cycles, and its strobe is high only in the second one. Strobes are therefore never high in two adjacent cycles.
- R10: tx_line carries tx_src[k-1] for the whole of a slot owned by channel k. Otherwise tx_line is 1, which models an idle open-drain line.
- R11: After reset, and while the engine has been disabled for a cycle, all strobes are 0 and tx_line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; also locks the table |
| dbl_speed | input | 1 | Two clock cycles per data bit |
| shared_sync | input | 1 | rx_sync also starts the transmit walk |
| rx_sync | input | 1 | Receive frame sync |
| tx_sync | input | 1 | Transmit frame sync when not shared |
| rx_line | input | 1 | Received serial bit |
| tx_src | input | NCH | Transmit bit offered by each channel |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | log2(2*NE) | Table address |
| cfg_wdata | input | 9 | Table entry word |
| rx_strobe | output | NCH | Per-channel receive bit strobe |
| rx_data | output | 1 | Received bit qualified by the strobe |
| tx_strobe | output | NCH | Per-channel transmit bit request |
| tx_line | output | 1 | Serial transmit output |

## Verification
Some properties are checked on every cycle. The strobes stay one-hot or idle. tx_line idles high when no slot is served at normal speed. A disabled engine stays silent. A sync sends the receive walk back to entry 0. Double-speed strobes never fall in adjacent cycles. Other behaviour can only be shown by the bench's scenarios against its behavioural model: slot lengths in bits and bytes, skipped selectors, the stop on the last flag or at the end of the table, writes locked out while enabled, the separate transmit sync, and the per-frame strobe totals per channel.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int SEL_W = 4;
    localparam int CNT_W = 3;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic             byte_unit;
        logic             last;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_RUN
    } walk_state_e;
endpackage

// File: rtl/tsa_table.sv
module tsa_table
    import tsa_pkg::*;
#(
    parameter int NE = 8,
    localparam int IW = $clog2(NE),
    localparam int AW = $clog2(2 * NE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wdata,
    input  logic [IW-1:0] ridx [2],
    output entry_t        rent [2]
);
    entry_t mem [2*NE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2 * NE; i++) begin
                mem[i] <= '0;
            end
        end else if (we && !lock) begin
            mem[waddr] <= wdata;
        end
    end

    // direction 0 = transmit half at offset 0, direction 1 = receive half at offset NE
    always_comb begin
        for (int d = 0; d < 2; d++) begin
            rent[d] = mem[AW'(d * NE) + AW'(ridx[d])];
        end
    end
endmodule

// File: rtl/tsa_walker.sv
module tsa_walker
    import tsa_pkg::*;
#(
    parameter int NE  = 8,
    parameter int NCH = 4,
    localparam int IW = $clog2(NE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           dbl,
    input  logic           sync,
    input  entry_t         ent,
    output logic [IW-1:0]  idx,
    output logic [NCH-1:0] owner,
    output logic [NCH-1:0] strobe
);
    localparam int LW = CNT_W + 3;

    walk_state_e   st_q, st_d;
    logic [IW-1:0] idx_d;
    logic [LW-1:0] pos_q, pos_d, len_m1;
    logic          ph_q, ph_d, tick;

    always_comb begin
        len_m1 = ent.byte_unit ? {ent.cnt, 3'b111} : LW'(ent.cnt);
        tick   = !dbl || ph_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            idx   <= '0;
            pos_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            idx   <= idx_d;
            pos_q <= pos_d;
            ph_q  <= ph_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        idx_d = idx;
        pos_d = pos_q;
        ph_d  = dbl ? ~ph_q : 1'b0;
        unique case (st_q)
            ST_OFF:  st_d = ST_WAIT;
            ST_WAIT: st_d = ST_WAIT;
            ST_RUN: begin
                if (tick) begin
                    if (pos_q == len_m1) begin
                        pos_d = '0;
                        if (ent.last || idx == IW'(NE - 1)) begin
                            st_d = ST_WAIT;
                        end else begin
                            idx_d = idx + 1'b1;
                        end
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
            end
        endcase
        if (!en) begin
            st_d = ST_OFF;
            ph_d = 1'b0;
        end else if (sync) begin
            st_d  = ST_RUN;
            idx_d = '0;
            pos_d = '0;
            ph_d  = 1'b0;
        end
    end

    // outputs
    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            owner[k] = (st_q == ST_RUN) && (ent.sel == SEL_W'(k + 1));
        end
        strobe = tick ? owner : '0;
    end
endmodule

// File: rtl/tsa_engine.sv
module tsa_engine
    import tsa_pkg::*;
#(
    parameter int NE  = 8,
    parameter int NCH = 4,
    localparam int IW = $clog2(NE),
    localparam int AW = $clog2(2 * NE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               dbl_speed,
    input  logic               shared_sync,
    input  logic               rx_sync,
    input  logic               tx_sync,
    input  logic               rx_line,
    input  logic [NCH-1:0]     tx_src,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    output logic [NCH-1:0]     rx_strobe,
    output logic               rx_data,
    output logic [NCH-1:0]     tx_strobe,
    output logic               tx_line
);
    logic [IW-1:0]  w_idx  [2];
    entry_t         w_ent  [2];
    logic [NCH-1:0] w_own  [2];
    logic [NCH-1:0] w_stb  [2];
    logic           w_sync [2];
    logic [IW-1:0]  rx_idx_w;

    assign w_sync[0] = shared_sync ? rx_sync : tx_sync;
    assign w_sync[1] = rx_sync;

    tsa_table #(.NE(NE)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .lock  (en),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (entry_t'(cfg_wdata)),
        .ridx  (w_idx),
        .rent  (w_ent)
    );

    generate
        for (genvar d = 0; d < 2; d++) begin : g_dir
            tsa_walker #(.NE(NE), .NCH(NCH)) u_walk (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (en),
                .dbl    (dbl_speed),
                .sync   (w_sync[d]),
                .ent    (w_ent[d]),
                .idx    (w_idx[d]),
                .owner  (w_own[d]),
                .strobe (w_stb[d])
            );
        end
    endgenerate

    assign rx_idx_w  = w_idx[1];
    assign rx_strobe = w_stb[1];
    assign rx_data   = rx_line & (|w_stb[1]);
    assign tx_strobe = w_stb[0];
    assign tx_line   = (w_own[0] == '0) ? 1'b1 : |(w_own[0] & tx_src);
endmodule

// File: rtl/tsa_engine_chk.sv
module tsa_engine_chk #(
    parameter int NCH = 4,
    parameter int IW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic           dbl_speed,
    input logic           rx_sync,
    input logic [NCH-1:0] rx_strobe,
    input logic [NCH-1:0] tx_strobe,
    input logic           tx_line,
    input logic [IW-1:0]  rx_idx
);
    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_strobe) && $onehot0(tx_strobe));

    assert_restart_entry0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_sync) |=> (rx_idx == '0));

    assert_dbl_no_adjacent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_speed && rx_strobe != '0) |=> (!dbl_speed || rx_strobe == '0));

    assert_tx_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_speed && tx_strobe == '0) |-> tx_line);

    assert_disabled_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (rx_strobe == '0 && tx_strobe == '0 && tx_line));
endmodule

bind tsa_engine tsa_engine_chk #(.NCH(NCH), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .dbl_speed (dbl_speed),
    .rx_sync   (rx_sync),
    .rx_strobe (rx_strobe),
    .tx_strobe (tx_strobe),
    .tx_line   (tx_line),
    .rx_idx    (rx_idx_w)
);

// File: tb/tb_tsa_engine.sv
`timescale 1ns/1ps
module tb_tsa_engine;
    localparam int NE = 8;
    localparam int NCH = 4;

    logic clk = 0;
    always #4 clk = ~clk;

    logic rst_n = 0, en = 0, dbl_speed = 0, shared_sync = 1;
    logic rx_sync = 0, tx_sync = 0, rx_line = 0;
    logic [NCH-1:0] tx_src = '0;
    logic cfg_we = 0;
    logic [3:0] cfg_addr = '0;
    logic [8:0] cfg_wdata = '0;
    logic [NCH-1:0] rx_strobe, tx_strobe;
    logic rx_data, tx_line;

    tsa_engine #(.NE(NE), .NCH(NCH)) dut (.*);

    int checks = 0, errors = 0;
    logic [8:0] mir [2*NE];
    bit m_run [2];
    int m_idx [2], m_pos [2];
    bit m_ph [2];
    bit cmp_on = 0, cnt_on = 0;
    int rx_cnt [NCH], tx_cnt [NCH];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] ent(input int sel, input int cnt, input int u, input int l);
        return {4'(sel), 3'(cnt), 1'(u), 1'(l)};
    endfunction

    function automatic int elen(input logic [8:0] e);
        return (int'(e[4:2]) + 1) * (e[1] ? 8 : 1);
    endfunction

    function automatic int exp_count(input int d, input int ch);
        int s = 0;
        for (int i = 0; i < NE; i++) begin
            if (int'(mir[d*NE+i][8:5]) == ch + 1) s += elen(mir[d*NE+i]);
            if (mir[d*NE+i][0]) break;
        end
        return s;
    endfunction

    function automatic logic [NCH-1:0] exp_hot(input int d);
        int sel;
        if (!m_run[d]) return '0;
        sel = int'(mir[d*NE+m_idx[d]][8:5]);
        if (sel >= 1 && sel <= NCH) return NCH'(1) << (sel - 1);
        return '0;
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2*NE; i++) mir[i] = '0;
            for (int d = 0; d < 2; d++) begin m_run[d] = 0; m_idx[d] = 0; m_pos[d] = 0; m_ph[d] = 0; end
        end else begin
            for (int d = 0; d < 2; d++) begin
                bit sy, tk;
                logic [8:0] e;
                sy = (d == 1) ? rx_sync : (shared_sync ? rx_sync : tx_sync);
                if (!en) begin
                    m_run[d] = 0; m_ph[d] = 0;
                end else begin
                    tk = !dbl_speed || m_ph[d];
                    if (m_run[d] && tk) begin
                        e = mir[d*NE+m_idx[d]];
                        if (m_pos[d] == elen(e) - 1) begin
                            m_pos[d] = 0;
                            if (e[0] || m_idx[d] == NE - 1) m_run[d] = 0;
                            else m_idx[d]++;
                        end else m_pos[d]++;
                    end
                    m_ph[d] = dbl_speed ? !m_ph[d] : 1'b0;
                    if (sy) begin m_run[d] = 1; m_idx[d] = 0; m_pos[d] = 0; m_ph[d] = 0; end
                end
            end
            if (cfg_we && !en) mir[cfg_addr] = cfg_wdata;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic [NCH-1:0] h0, h1, s0, s1;
            bit tk0, tk1, etx;
            h0 = exp_hot(0); h1 = exp_hot(1);
            tk0 = !dbl_speed || m_ph[0]; tk1 = !dbl_speed || m_ph[1];
            s0 = tk0 ? h0 : '0; s1 = tk1 ? h1 : '0;
            etx = (h0 == '0) ? 1'b1 : |(h0 & tx_src);
            chk(rx_strobe == s1, "R3", "rx_strobe", rx_strobe, s1);
            chk(tx_strobe == s0, "R3", "tx_strobe", tx_strobe, s0);
            chk(tx_line == etx, "R10", "tx_line", tx_line, etx);
            chk(rx_data == (rx_line && s1 != '0), "R3", "rx_data", rx_data, rx_line && s1 != '0);
            if (cnt_on) for (int k = 0; k < NCH; k++) begin
                rx_cnt[k] += rx_strobe[k]; tx_cnt[k] += tx_strobe[k];
            end
        end
    end

    always @(posedge clk) begin
        #1;
        rx_line <= 1'($urandom);
        tx_src  <= NCH'($urandom);
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input int a, input logic [8:0] w);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = w;
        step();
        cfg_we = 0;
    endtask

    task automatic frame(input bit srx, input bit stx, input int ncyc, input string req);
        for (int k = 0; k < NCH; k++) begin rx_cnt[k] = 0; tx_cnt[k] = 0; end
        cnt_on = 1;
        rx_sync = srx; tx_sync = stx;
        step();
        rx_sync = 0; tx_sync = 0;
        step(ncyc);
        cnt_on = 0;
        for (int k = 0; k < NCH; k++) begin
            int erx, etx;
            erx = srx ? exp_count(1, k) : 0;
            etx = (stx || (srx && shared_sync)) ? exp_count(0, k) : 0;
            chk(rx_cnt[k] == erx, req, $sformatf("rx strobes ch%0d per frame", k), rx_cnt[k], erx);
            chk(tx_cnt[k] == etx, req, $sformatf("tx strobes ch%0d per frame", k), tx_cnt[k], etx);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk(rx_strobe == '0 && tx_strobe == '0, "R11", "strobes after reset", {rx_strobe, tx_strobe}, 0);
        chk(tx_line == 1'b1, "R11", "tx_line after reset", tx_line, 1);
        step();
        cmp_on = 1;
        // R6: receive half at NE, transmit half at 0
        wr(8,  ent(2, 0, 1, 0));
        wr(9,  ent(3, 0, 1, 0));
        wr(10, ent(4, 0, 1, 0));
        wr(11, ent(1, 1, 0, 0));
        wr(12, ent(4, 5, 0, 0));
        wr(13, ent(0, 6, 1, 0));
        wr(14, ent(0, 1, 0, 0));
        wr(15, ent(1, 0, 0, 1));
        wr(0,  ent(1, 1, 1, 0));
        wr(1,  ent(9, 2, 0, 0));
        wr(2,  ent(3, 2, 0, 1));
        en = 1;
        step(2);
        // R1/R4/R6: whole frames, counts per channel
        frame(1, 0, 120, "R1");
        frame(1, 0, 120, "R4");
        // R2: skip region of receive frame, transmit walk already over
        rx_sync = 1; step(); rx_sync = 0;
        step(39);
        @(negedge clk);
        chk(rx_strobe == '0, "R2", "rx strobe in skipped slot", rx_strobe, 0);
        chk(tx_line == 1'b1, "R10", "tx_line after transmit walk ends", tx_line, 1);
        step(80);
        // R7: write while enabled ignored
        wr(8, ent(0, 0, 1, 0));
        frame(1, 0, 120, "R7");
        chk(exp_count(1, 1) == 8, "R7", "mirror ch1 bits unchanged", exp_count(1, 1), 8);
        // R5: mid-frame restart
        rx_sync = 1; step(); rx_sync = 0;
        step(20);
        rx_sync = 1; step(); rx_sync = 0;
        @(negedge clk);
        chk(rx_strobe == 4'b0010, "R5", "strobe at entry 0 after restart", rx_strobe, 2);
        step(120);
        // R8: separate syncs
        shared_sync = 0;
        frame(1, 0, 120, "R8");
        frame(0, 1, 120, "R8");
        shared_sync = 1;
        // R9: double speed
        dbl_speed = 1;
        frame(1, 0, 230, "R9");
        dbl_speed = 0;
        step(2);
        // R4: walk ends at end of table without last flag
        en = 0; step();
        wr(2, ent(3, 2, 0, 0));
        en = 1; step();
        frame(1, 0, 120, "R4");
        // R11: sync while disabled does nothing
        en = 0; step();
        rx_sync = 1; step(); rx_sync = 0;
        @(negedge clk);
        chk(rx_strobe == '0 && tx_line == 1'b1, "R11", "disabled ignores sync", rx_strobe, 0);
        // R6/R7: write while disabled takes effect
        wr(8, ent(3, 1, 1, 0));
        en = 1; step();
        frame(1, 0, 120, "R6");
        chk(exp_count(1, 2) == 24, "R6", "ch3 bits after write", exp_count(1, 2), 24);
        step(2);
        finish_run();
    end
endmodule